// File: doc/BRIEF.md
# Code-Density Calibration Mapping Engine

This block produces the calibration lookup table for one tapped-delay-line time-to-digital converter. After a start request it blanks its hit histogram and its mapping table, one address per clock. It then accepts a fixed power-of-two number of raw tap codes produced by hits that are uncorrelated with the sampling clock, and counts how often each tap was the end of the line. Last, it walks the taps from the lowest upward, keeps a running total of the counts, and turns that total into a quantized calibrated bin code for each tap. Because the number of hits is a power of two, the scaling from counts to bins is a right shift.

The raw codes arrive on a valid/ready stream. The engine raises `in_ready` only while it is collecting hits. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. When `in_ready` is low, an upstream source that needs every code must hold it. A free-running calibration source may drop it instead, and the engine ignores the code. `start`, `done` and the table read port are plain signals. Lookups return the stored word one clock after the address is presented.

Top module: `cdc_cal_engine`

## Requirements
- R1: While reset is held and after it is released, `done` and `in_ready` are low and the engine waits for `start`.
- R2: A `start` pulse accepted while waiting causes a blanking phase of exactly 2^TAP_W clocks, one address per clock. In that phase every histogram count and every mapping word is set to zero. `in_ready` rises on the clock after the last address, and every table read from then until the first new write returns 0.
- R3: `in_ready` is high only in the collection phase. Exactly 2^HIT_LOG2 transfers are accepted, and `in_ready` falls on the clock after the last one. Codes offered while `in_ready` is low leave the table unchanged.
- R4: Every accepted code adds one to the count of the tap it names. This holds when consecutive transfers name the same tap.
- R5: For tap n, the stored word is floor(S_n / 2^(HIT_LOG2-OUT_W)), limited to 2^OUT_W-1 and zero-extended to WORD_W bits. S_n is the sum of the counts of taps 0 through n.
- R6: No stored word exceeds 2^OUT_W-1. A tap whose running total reaches every hit stores exactly 2^OUT_W-1.
- R7: The words written during table construction never decrease from one tap to the next.
- R8: `done` is high for exactly one clock, on the clock after the write for the highest tap. At that point the whole table is valid.
- R9: `rd_data` shows the word stored at `rd_addr` one clock after `rd_addr` is applied.
- R10: A `start` that arrives while a calibration is in progress has no effect. The table is unchanged, one `done` is produced, and no second calibration follows.
- R11: A `start` after `done` recalibrates from nothing. Counts from the earlier run do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Calibration request, taken only while waiting |
| in_valid | input | 1 | Raw tap code offered |
| in_ready | output | 1 | Engine collecting hits |
| in_code | input | TAP_W | Raw tap code |
| done | output | 1 | One-clock pulse when the table is complete |
| rd_addr | input | TAP_W | Lookup address (tap) |
| rd_data | output | WORD_W | Calibrated word for the tap, one clock later |

## Verification
The bench builds the engine with TAP_W=4, HIT_LOG2=8, OUT_W=3 and WORD_W=4. That gives 16 taps, 256 hits per calibration and a shift of five. With these values a whole calibration takes a few hundred clocks, so several full runs fit back to back. They cover a uniform spread, every hit on one tap, a gapped pseudo-random stream and a tail-heavy spread. When every hit lands on one tap, the running total reaches 256, which is past the 3-bit maximum, so saturation is exercised. Long runs of repeated codes test the read-modify-write forwarding. Because the table has only 16 entries, the bench reads back every word after every run.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_RUN,
    PH_FLUSH,
    PH_SUM,
    PH_FINAL
  } cal_phase_e;
endpackage

// File: rtl/cdc_hist_bank.sv
// Histogram storage: one registered read port, one write port.
module cdc_hist_bank #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cdc_hit_pipe.sv
// Read-modify-write increment stage with one-deep forwarding of the
// previous write, so back-to-back hits on one tap are all counted.
module cdc_hit_pipe #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_vld,
  input  logic [ADDR_W-1:0] hit_code,
  input  logic [CNT_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_data
);
  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;
  logic              lw_vld;
  logic [ADDR_W-1:0] lw_addr;
  logic [CNT_W-1:0]  lw_data;
  logic [CNT_W-1:0]  base;

  always_comb begin
    base    = (lw_vld && (lw_addr == s1_addr)) ? lw_data : rd_data;
    wr_en   = s1_vld;
    wr_addr = s1_addr;
    wr_data = base + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      lw_vld  <= 1'b0;
      lw_addr <= '0;
      lw_data <= '0;
    end else begin
      s1_vld  <= hit_vld;
      s1_addr <= hit_code;
      lw_vld  <= s1_vld;
      lw_addr <= s1_addr;
      lw_data <= wr_data;
    end
  end
endmodule

// File: rtl/cdc_cum_quant.sv
// Running sum of per-tap counts and conversion to a saturated bin code.
module cdc_cum_quant #(
  parameter int CNT_W  = 18,
  parameter int CUM_W  = 19,
  parameter int OUT_W  = 7,
  parameter int WORD_W = 8,
  parameter int SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_vld,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic [WORD_W-1:0] word
);
  localparam logic [CUM_W-1:0] MAX_CODE = CUM_W'((1 << OUT_W) - 1);

  logic [CUM_W-1:0] cum_q;
  logic [CUM_W-1:0] cum_next;
  logic [CUM_W-1:0] scaled;
  logic [CUM_W-1:0] limited;
  logic [OUT_W-1:0] code;

  always_comb begin
    cum_next = cum_q + CUM_W'(in_cnt);
    scaled   = cum_next >> SHIFT;
    limited  = (scaled > MAX_CODE) ? MAX_CODE : scaled;
    code     = limited[OUT_W-1:0];
  end

  generate
    if (WORD_W > OUT_W) begin : g_pad
      assign word = {{(WORD_W - OUT_W){1'b0}}, code};
    end else begin : g_same
      assign word = code;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cum_q <= '0;
    else if (in_vld)   cum_q <= cum_next;
  end
endmodule

// File: rtl/cdc_map_mem.sv
// Calibrated mapping table: one write port, one registered lookup port.
module cdc_map_mem #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cdc_cal_engine.sv
// Sequencer and datapath glue: blank, collect hits, build the table.
module cdc_cal_engine #(
  parameter int TAP_W    = 9,
  parameter int HIT_LOG2 = 17,
  parameter int OUT_W    = 7,
  parameter int WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAP_W-1:0]  in_code,
  output logic              done,
  input  logic [TAP_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  import cdc_pkg::*;

  localparam int CNT_W = HIT_LOG2 + 1;
  localparam int CUM_W = HIT_LOG2 + 2;
  localparam int SHIFT = HIT_LOG2 - OUT_W;
  localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_HIT = CNT_W'((1 << HIT_LOG2) - 1);

  cal_phase_e        phase_q;
  logic [TAP_W-1:0]  addr_q;
  logic [CNT_W-1:0]  hit_cnt_q;
  logic              sum_vld_q;
  logic [TAP_W-1:0]  sum_addr_q;
  logic              done_q;
  logic              accept;

  logic              h_rd_en;
  logic [TAP_W-1:0]  h_rd_addr;
  logic [CNT_W-1:0]  h_rd_data;
  logic              h_wr_en;
  logic [TAP_W-1:0]  h_wr_addr;
  logic [CNT_W-1:0]  h_wr_data;
  logic              p_wr_en;
  logic [TAP_W-1:0]  p_wr_addr;
  logic [CNT_W-1:0]  p_wr_data;

  logic              map_we;
  logic [TAP_W-1:0]  map_wa;
  logic [WORD_W-1:0] map_wd;
  logic [WORD_W-1:0] q_word;

  assign in_ready = (phase_q == PH_RUN);
  assign accept   = in_ready && in_valid;
  assign done     = done_q;

  // Phase sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      addr_q    <= '0;
      hit_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_CLEAR;
            addr_q  <= '0;
          end
        end
        PH_CLEAR: begin
          addr_q <= addr_q + TAP_W'(1);
          if (addr_q == LAST_TAP) begin
            phase_q   <= PH_RUN;
            hit_cnt_q <= '0;
          end
        end
        PH_RUN: begin
          if (accept) begin
            hit_cnt_q <= hit_cnt_q + CNT_W'(1);
            if (hit_cnt_q == LAST_HIT) phase_q <= PH_FLUSH;
          end
        end
        PH_FLUSH: begin
          phase_q <= PH_SUM;
          addr_q  <= '0;
        end
        PH_SUM: begin
          addr_q <= addr_q + TAP_W'(1);
          if (addr_q == LAST_TAP) phase_q <= PH_FINAL;
        end
        PH_FINAL: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_vld_q  <= 1'b0;
      sum_addr_q <= '0;
      done_q     <= 1'b0;
    end else begin
      sum_vld_q  <= (phase_q == PH_SUM);
      sum_addr_q <= addr_q;
      done_q     <= (phase_q == PH_FINAL);
    end
  end

  // Histogram port steering
  always_comb begin
    h_rd_en   = accept || (phase_q == PH_SUM);
    h_rd_addr = (phase_q == PH_SUM) ? addr_q : in_code;
    if (phase_q == PH_CLEAR) begin
      h_wr_en   = 1'b1;
      h_wr_addr = addr_q;
      h_wr_data = '0;
    end else begin
      h_wr_en   = p_wr_en;
      h_wr_addr = p_wr_addr;
      h_wr_data = p_wr_data;
    end
  end

  // Mapping table write steering
  always_comb begin
    if (phase_q == PH_CLEAR) begin
      map_we = 1'b1;
      map_wa = addr_q;
      map_wd = '0;
    end else begin
      map_we = sum_vld_q;
      map_wa = sum_addr_q;
      map_wd = q_word;
    end
  end

  cdc_hist_bank #(.ADDR_W(TAP_W), .DATA_W(CNT_W)) u_hist (
    .clk     (clk),
    .rd_en   (h_rd_en),
    .rd_addr (h_rd_addr),
    .rd_data (h_rd_data),
    .wr_en   (h_wr_en),
    .wr_addr (h_wr_addr),
    .wr_data (h_wr_data)
  );

  cdc_hit_pipe #(.ADDR_W(TAP_W), .CNT_W(CNT_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vld  (accept),
    .hit_code (in_code),
    .rd_data  (h_rd_data),
    .wr_en    (p_wr_en),
    .wr_addr  (p_wr_addr),
    .wr_data  (p_wr_data)
  );

  cdc_cum_quant #(
    .CNT_W(CNT_W), .CUM_W(CUM_W), .OUT_W(OUT_W), .WORD_W(WORD_W), .SHIFT(SHIFT)
  ) u_quant (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (phase_q == PH_FLUSH),
    .in_vld (sum_vld_q),
    .in_cnt (h_rd_data),
    .word   (q_word)
  );

  cdc_map_mem #(.ADDR_W(TAP_W), .WORD_W(WORD_W)) u_map (
    .clk     (clk),
    .wr_en   (map_we),
    .wr_addr (map_wa),
    .wr_data (map_wd),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/cdc_cal_engine_chk.sv
module cdc_cal_engine_chk #(
  parameter int TAP_W    = 9,
  parameter int HIT_LOG2 = 17,
  parameter int OUT_W    = 7,
  parameter int WORD_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                done,
  input cdc_pkg::cal_phase_e phase,
  input logic                map_we,
  input logic [WORD_W-1:0]   map_wd
);
  import cdc_pkg::*;

  localparam int CNT_W = HIT_LOG2 + 1;
  localparam logic [CNT_W-1:0]   TOTAL    = CNT_W'(1 << HIT_LOG2);
  localparam logic [CNT_W-1:0]   LAST_HIT = CNT_W'((1 << HIT_LOG2) - 1);
  localparam logic [TAP_W:0]     TAPS     = (TAP_W + 1)'(1 << TAP_W);
  localparam logic [WORD_W-1:0]  MAXW     = WORD_W'((1 << OUT_W) - 1);

  logic [CNT_W-1:0] acc_cnt;
  logic [TAP_W:0]   clr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_ready) acc_cnt <= '0;
    else if (in_valid)       acc_cnt <= acc_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || phase == PH_IDLE) clr_cnt <= '0;
    else if (phase == PH_CLEAR)     clr_cnt <= clr_cnt + (TAP_W + 1)'(1);
  end

  p_clear_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> clr_cnt == TAPS);

  p_hit_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> acc_cnt < TOTAL);

  p_ready_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> ($past(acc_cnt) == LAST_HIT && $past(in_valid)));

  p_code_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> map_wd <= MAXW);

  p_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && phase != PH_CLEAR && $past(map_we) && $past(phase) != PH_CLEAR)
      |-> map_wd >= $past(map_wd));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
endmodule

bind cdc_cal_engine cdc_cal_engine_chk #(
  .TAP_W(TAP_W), .HIT_LOG2(HIT_LOG2), .OUT_W(OUT_W), .WORD_W(WORD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .phase    (phase_q),
  .map_we   (map_we),
  .map_wd   (map_wd)
);

// File: tb/cdc_cal_engine_tb.sv
module cdc_cal_engine_tb;
  localparam int TAP_W    = 4;
  localparam int HIT_LOG2 = 8;
  localparam int OUT_W    = 3;
  localparam int WORD_W   = 4;
  localparam int TAPS     = 1 << TAP_W;
  localparam int TOTAL    = 1 << HIT_LOG2;
  localparam int SHIFT    = HIT_LOG2 - OUT_W;
  localparam int MAXC     = (1 << OUT_W) - 1;
  localparam time CLK_P   = 20ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [TAP_W-1:0]  in_code = '0;
  logic              done;
  logic [TAP_W-1:0]  rd_addr = '0;
  logic [WORD_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int hist [TAPS];
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_P / 2) clk = ~clk;

  cdc_cal_engine #(
    .TAP_W(TAP_W), .HIT_LOG2(HIT_LOG2), .OUT_W(OUT_W), .WORD_W(WORD_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Read a table word: address at a falling edge, data at the next one (R9).
  task automatic read_word(input int a, output int v);
    @(negedge clk);
    rd_addr = TAP_W'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 done low in reset", int'(done), 0);
    chk("R1 ready low in reset", int'(in_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done low after reset", int'(done), 0);
    chk("R1 ready low after reset", int'(in_ready), 0);
  endtask

  function automatic logic [TAP_W-1:0] pick(input int pat, input int n);
    case (pat)
      0: return TAP_W'(n % TAPS);
      1: return TAP_W'(5);
      2: return lfsr[TAP_W-1:0];
      default: return (n < TOTAL / 4) ? TAP_W'(n % 3) : TAP_W'(TAPS - 1);
    endcase
  endfunction

  // One full calibration with a given hit pattern.
  task automatic t_calibrate(input int pat, input bit poke_start);
    int k, acc, v, cum, q, dcnt;
    bit gap;
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    @(negedge clk);
    start = 1'b1;
    in_valid = 1'b1;   // offered while not ready: must be ignored (R3)
    in_code = TAP_W'(3);
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (in_ready || k > 4 * TAPS) break;
      @(posedge clk);
      k++;
    end
    in_valid = 1'b0;
    chk("R2 blanking length", k, TAPS);
    for (int a = 0; a < TAPS; a++) begin
      read_word(a, v);
      chk("R2 table blank", v, 0);
    end
    chk("R3 ready held during reads", int'(in_ready), 1);
    acc = 0;
    while (acc < TOTAL) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      gap = (pat == 2) && lfsr[6] && lfsr[1];
      start = (poke_start && acc == 100) ? 1'b1 : 1'b0;
      in_valid = !gap;
      in_code = pick(pat, acc);
      if (in_valid && in_ready) begin
        hist[in_code]++;
        acc++;
      end
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1;   // extra hits after the quota (R3)
    in_code = TAP_W'(0);
    chk("R3 ready falls after quota", int'(in_ready), 0);
    dcnt = 0;
    for (int c = 0; c < 4 * TAPS && !done; c++) @(negedge clk);
    in_valid = 1'b0;
    chk("R8 done seen", int'(done), 1);
    @(negedge clk);
    chk("R8 done one clock", int'(done), 0);
    cum = 0;
    for (int a = 0; a < TAPS; a++) begin
      cum += hist[a];
      q = cum >> SHIFT;
      if (q > MAXC) q = MAXC;
      read_word(a, v);
      chk($sformatf("R5 R4 word tap %0d pat %0d", a, pat), v, q);
    end
    if (pat == 1) begin
      read_word(TAPS - 1, v);
      chk("R6 saturated top", v, MAXC);
    end
    if (poke_start) begin
      for (int c = 0; c < 3 * TAPS; c++) begin
        @(negedge clk);
        if (in_ready || done) dcnt++;
      end
      chk("R10 no second calibration", dcnt, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_calibrate(0, 1'b0);   // uniform spread
    t_calibrate(1, 1'b0);   // all on one tap, R11 restart from scratch
    t_calibrate(2, 1'b1);   // gapped pseudo-random, start poked mid-run
    t_calibrate(3, 1'b0);   // tail heavy
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule